// File: doc/BRIEF.md
# Next Code-Block Address Resolver

This unit decides where execution continues once a block of instructions has run to its end. While a block executes, up to `NJ` jump instructions per cycle present their evaluation results on parallel lanes. Lane 0 is the earliest in program order and lane `NJ-1` the latest. Each lane carries a kind, a condition operand and a target address.

The condition operand normally comes from a compare instruction that yields 1 for true and 0 for false. Any value is accepted, and only its zero or nonzero state matters. A block may also load a default-address register, which is used when no jump in the block is taken.

When the end-of-block strobe arrives, the unit issues exactly one next-address result on the following cycle. It then forgets all jump and default state, so the following block starts clean. Jumps and default writes presented in the same cycle as the end strobe still belong to the ending block.

Top module: `next_block_resolver`

## Requirements
- R1: `next_valid` is high for exactly one cycle, in the cycle after each cycle with `end_valid` high, and is low in every other cycle; `next_addr` keeps its last value while `next_valid` is low.
- R2: A valid lane of kind 0 (kind field of lane i at `jmp_kind[2i+1:2i]`) is taken whatever its condition operand.
- R3: A valid lane of kind 1 is taken only when its condition operand equals zero.
- R4: A valid lane of kind 2 is taken only when its condition operand is nonzero.
- R5: A lane of kind 3, or a lane whose `jmp_valid` bit is low, is never taken.
- R6: When several lanes are taken in the same cycle, the lowest-numbered lane supplies the target.
- R7: A jump taken in an earlier cycle of a block wins over every jump taken later in that block, including in the end cycle.
- R8: With no jump taken, the next address is the default address most recently written in the block; a write in the end cycle counts and overrides older writes.
- R9: With no jump taken and no default write in the block, the next address is `end_addr + 1` modulo 2^AW.
- R10: After a result is issued, no jump or default state of the finished block affects the next block.
- R11: During and right after reset, `next_valid` is 0, `next_addr` is 0, and no jump or default is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_valid | input | NJ | Per-lane jump present this cycle |
| jmp_kind | input | 2*NJ | Per-lane kind: 0 always, 1 if zero, 2 if nonzero, 3 never |
| jmp_cond | input | DW*NJ | Per-lane condition operand |
| jmp_target | input | AW*NJ | Per-lane target address |
| dflt_we | input | 1 | Write the default-address register |
| dflt_addr | input | AW | Default address to write |
| end_valid | input | 1 | End-of-block marker retires |
| end_addr | input | AW | Address of the end-of-block marker |
| next_valid | output | 1 | Next address is valid (one-cycle pulse) |
| next_addr | output | AW | Chosen next block address |

## Verification
On every cycle, the checker confirms the following:
- the one-cycle pairing of the end strobe with the result pulse;
- the clearing of pending state at each issue;
- the dominance of a jump held from an earlier cycle;
- lane 0 unconditional selection;
- fall-through with wraparound;
- selection of a default written in the end cycle.

Only the bench scenarios show the remaining behaviours:
- the zero and nonzero conditional kinds;
- lane ordering between two taken lanes;
- a reserved kind being ignored;
- latest-write-wins on the default register;
- the absence of leakage from one block into the next across back-to-back blocks.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

   typedef enum logic [1:0] {
      JK_ALWAYS     = 2'd0,
      JK_IF_ZERO    = 2'd1,
      JK_IF_NONZERO = 2'd2,
      JK_NEVER      = 2'd3
   } jkind_e;

   localparam int unsigned KIND_W = 2;

endpackage

// File: rtl/nbr_lane_eval.sv
module nbr_lane_eval #(
   parameter int unsigned DW = 32
) (
   input  logic          valid,
   input  logic [1:0]    kind,
   input  logic [DW-1:0] cond,
   output logic          take
);
   import nbr_pkg::*;

   jkind_e kind_e;
   logic   is_zero;

   assign kind_e  = jkind_e'(kind);
   assign is_zero = (cond == '0);

   always_comb begin
      take = 1'b0;
      if (valid) begin
         unique case (kind_e)
            JK_ALWAYS:     take = 1'b1;
            JK_IF_ZERO:    take = is_zero;
            JK_IF_NONZERO: take = !is_zero;
            default:       take = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/nbr_first_pick.sv
module nbr_first_pick #(
   parameter int unsigned NJ = 2,
   parameter int unsigned AW = 16
) (
   input  logic [NJ-1:0]    take,
   input  logic [NJ*AW-1:0] targets,
   output logic             any,
   output logic [AW-1:0]    addr
);
   logic [NJ:0] seen;
   logic [AW-1:0] chain [NJ+1];

   assign seen[NJ]  = 1'b0;
   assign chain[NJ] = '0;

   for (genvar i = NJ - 1; i >= 0; i--) begin : g_chain
      assign seen[i]  = take[i] | seen[i+1];
      assign chain[i] = take[i] ? targets[i*AW +: AW] : chain[i+1];
   end

   assign any  = seen[0];
   assign addr = chain[0];
endmodule

// File: rtl/nbr_state.sv
module nbr_state #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          blk_end,
   input  logic          jump_now,
   input  logic [AW-1:0] jump_addr,
   input  logic          dflt_we,
   input  logic [AW-1:0] dflt_addr,
   output logic          taken_q,
   output logic [AW-1:0] tgt_q,
   output logic          dflt_v_q,
   output logic [AW-1:0] dflt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n || blk_end) begin
         taken_q  <= 1'b0;
         tgt_q    <= '0;
         dflt_v_q <= 1'b0;
         dflt_q   <= '0;
      end else begin
         if (!taken_q && jump_now) begin
            taken_q <= 1'b1;
            tgt_q   <= jump_addr;
         end
         if (dflt_we) begin
            dflt_v_q <= 1'b1;
            dflt_q   <= dflt_addr;
         end
      end
   end
endmodule

// File: rtl/next_block_resolver.sv
module next_block_resolver #(
   parameter int unsigned NJ = 2,
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NJ-1:0]    jmp_valid,
   input  logic [2*NJ-1:0]  jmp_kind,
   input  logic [DW*NJ-1:0] jmp_cond,
   input  logic [AW*NJ-1:0] jmp_target,
   input  logic             dflt_we,
   input  logic [AW-1:0]    dflt_addr,
   input  logic             end_valid,
   input  logic [AW-1:0]    end_addr,
   output logic             next_valid,
   output logic [AW-1:0]    next_addr
);
   localparam int unsigned KW = nbr_pkg::KIND_W;
   localparam logic [AW-1:0] STEP = AW'(1);

   if (NJ < 1 || NJ > 16) begin : g_bad_nj
      $error("NJ must be in 1..16");
   end
   if (AW < 2 || AW > 64) begin : g_bad_aw
      $error("AW must be in 2..64");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end

   logic [NJ-1:0] take;
   logic          any_now;
   logic [AW-1:0] pick_addr;
   logic          taken_q, dflt_v_q;
   logic [AW-1:0] tgt_q, dflt_q;
   logic [AW-1:0] fall_addr, sel_addr;

   for (genvar i = 0; i < NJ; i++) begin : g_lane
      nbr_lane_eval #(.DW(DW)) u_eval (
         .valid (jmp_valid[i]),
         .kind  (jmp_kind[i*KW +: KW]),
         .cond  (jmp_cond[i*DW +: DW]),
         .take  (take[i])
      );
   end

   nbr_first_pick #(.NJ(NJ), .AW(AW)) u_pick (
      .take    (take),
      .targets (jmp_target),
      .any     (any_now),
      .addr    (pick_addr)
   );

   nbr_state #(.AW(AW)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_end   (end_valid),
      .jump_now  (any_now),
      .jump_addr (pick_addr),
      .dflt_we   (dflt_we),
      .dflt_addr (dflt_addr),
      .taken_q   (taken_q),
      .tgt_q     (tgt_q),
      .dflt_v_q  (dflt_v_q),
      .dflt_q    (dflt_q)
   );

   assign fall_addr = end_addr + STEP;

   always_comb begin
      if (taken_q)        sel_addr = tgt_q;
      else if (any_now)   sel_addr = pick_addr;
      else if (dflt_we)   sel_addr = dflt_addr;
      else if (dflt_v_q)  sel_addr = dflt_q;
      else                sel_addr = fall_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_valid <= 1'b0;
         next_addr  <= '0;
      end else begin
         next_valid <= end_valid;
         if (end_valid) next_addr <= sel_addr;
      end
   end
endmodule

// File: rtl/nbr_chk.sv
module nbr_chk #(
   parameter int unsigned NJ = 2,
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NJ-1:0]    jmp_valid,
   input logic [2*NJ-1:0]  jmp_kind,
   input logic [AW*NJ-1:0] jmp_target,
   input logic             dflt_we,
   input logic [AW-1:0]    dflt_addr,
   input logic             end_valid,
   input logic [AW-1:0]    end_addr,
   input logic             next_valid,
   input logic [AW-1:0]    next_addr,
   input logic             taken_q,
   input logic [AW-1:0]    tgt_q,
   input logic             dflt_v_q
);
   logic [AW-1:0] fall_c;
   assign fall_c = end_addr + AW'(1);

   a_r1_issue_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      end_valid |=> next_valid);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !end_valid |=> !next_valid);

   a_r2_lane0_always: assert property (@(posedge clk) disable iff (!rst_n)
      (end_valid && !taken_q && jmp_valid[0] && jmp_kind[1:0] == 2'd0)
      |=> next_addr == $past(jmp_target[AW-1:0]));

   a_r7_held_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (end_valid && taken_q) |=> next_addr == $past(tgt_q));

   a_r8_default_end_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (end_valid && !taken_q && jmp_valid == '0 && dflt_we)
      |=> next_addr == $past(dflt_addr));

   a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (end_valid && !taken_q && !dflt_v_q && jmp_valid == '0 && !dflt_we)
      |=> next_addr == $past(fall_c));

   a_r10_cleared_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
      next_valid |-> (!taken_q && !dflt_v_q));
endmodule

bind next_block_resolver nbr_chk #(.NJ(NJ), .AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .jmp_valid  (jmp_valid),
   .jmp_kind   (jmp_kind),
   .jmp_target (jmp_target),
   .dflt_we    (dflt_we),
   .dflt_addr  (dflt_addr),
   .end_valid  (end_valid),
   .end_addr   (end_addr),
   .next_valid (next_valid),
   .next_addr  (next_addr),
   .taken_q    (taken_q),
   .tgt_q      (tgt_q),
   .dflt_v_q   (dflt_v_q)
);

// File: tb/sim_next_block_resolver.sv
module sim_next_block_resolver;
   localparam int NJ = 2;
   localparam int AW = 16;
   localparam int DW = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NJ-1:0]    jmp_valid = '0;
   logic [2*NJ-1:0]  jmp_kind = '0;
   logic [DW*NJ-1:0] jmp_cond = '0;
   logic [AW*NJ-1:0] jmp_target = '0;
   logic             dflt_we = 1'b0;
   logic [AW-1:0]    dflt_addr = '0;
   logic             end_valid = 1'b0;
   logic [AW-1:0]    end_addr = '0;
   logic             next_valid;
   logic [AW-1:0]    next_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [AW-1:0] q_exp [$];
   string         q_tag [$];

   always #5 clk = ~clk;

   next_block_resolver #(.NJ(NJ), .AW(AW), .DW(DW)) u0 (.*);

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n && next_valid) begin
         if (q_exp.size() == 0) begin
            check(1'b0, "R1 unexpected pulse", 1, 0);
         end else begin
            automatic logic [AW-1:0] e = q_exp.pop_front();
            automatic string t = q_tag.pop_front();
            check(next_addr == e, t, next_addr, e);
         end
      end
   end

   task automatic lane(input int i, input int k, input int c, input int t);
      jmp_valid[i]           = 1'b1;
      jmp_kind[2*i +: 2]     = 2'(k);
      jmp_cond[DW*i +: DW]   = DW'(c);
      jmp_target[AW*i +: AW] = AW'(t);
   endtask

   task automatic dflt(input int a);
      dflt_we   = 1'b1;
      dflt_addr = AW'(a);
   endtask

   task automatic cyc();
      @(negedge clk);
      jmp_valid = '0; jmp_kind = '0; jmp_cond = '0; jmp_target = '0;
      dflt_we = 1'b0; dflt_addr = '0; end_valid = 1'b0; end_addr = '0;
   endtask

   task automatic finish_blk(input int a, input int exp, input string tag);
      end_valid = 1'b1;
      end_addr  = AW'(a);
      q_exp.push_back(AW'(exp));
      q_tag.push_back(tag);
      cyc();
   endtask

   initial begin
      #2_000_000;
      check(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(next_valid == 1'b0, "R11 valid after reset", next_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(next_valid == 1'b0, "R11 valid idle", next_valid, 0);
      check(next_addr == '0, "R11 addr idle", next_addr, 0);

      // R9 fall-through and wrap
      finish_blk(16'h0100, 16'h0101, "R9 fallthrough");
      cyc();
      check(next_addr == 16'h0101, "R1 addr held", next_addr, 16'h0101);
      finish_blk(16'hFFFF, 16'h0000, "R9 wrap");
      // R2 always, cond irrelevant
      lane(0, 0, 7, 16'h1234); cyc();
      finish_blk(16'h0200, 16'h1234, "R2 always");
      // R3 if-zero taken / not taken
      lane(1, 1, 0, 16'h2222); cyc();
      finish_blk(16'h0300, 16'h2222, "R3 zero taken");
      lane(0, 1, 5, 16'h2223); cyc();
      finish_blk(16'h0300, 16'h0301, "R3 nonzero not taken");
      // R4 if-nonzero
      lane(0, 2, 1, 16'h3333); cyc();
      finish_blk(16'h0400, 16'h3333, "R4 nonzero taken");
      lane(1, 2, 0, 16'h3334); cyc();
      finish_blk(16'h0400, 16'h0401, "R4 zero not taken");
      // R5 reserved kind and invalid lane
      lane(0, 3, 0, 16'h4444); cyc();
      jmp_kind[1:0] = 2'd0; jmp_target[15:0] = 16'h4445; cyc();
      finish_blk(16'h0500, 16'h0501, "R5 never taken");
      // R6 lane order
      lane(0, 0, 0, 16'h5550); lane(1, 0, 0, 16'h5551); cyc();
      finish_blk(16'h0600, 16'h5550, "R6 lane0 wins");
      lane(0, 1, 9, 16'h5560); lane(1, 2, 9, 16'h5561); cyc();
      finish_blk(16'h0600, 16'h5561, "R6 lane1 when lane0 not taken");
      // R7 earlier cycle wins, also over end-cycle jump
      lane(1, 0, 0, 16'h6660); cyc();
      lane(0, 0, 0, 16'h6661); cyc();
      lane(0, 0, 0, 16'h6662);
      finish_blk(16'h0700, 16'h6660, "R7 earliest wins");
      // jump in end cycle counts
      lane(0, 2, 3, 16'h6670);
      finish_blk(16'h0700, 16'h6670, "R7 end-cycle jump");
      // R8 default
      dflt(16'h7770); cyc();
      finish_blk(16'h0800, 16'h7770, "R8 default");
      dflt(16'h7771); cyc(); dflt(16'h7772); cyc();
      finish_blk(16'h0800, 16'h7772, "R8 latest write");
      dflt(16'h7773); cyc();
      dflt(16'h7774);
      finish_blk(16'h0800, 16'h7774, "R8 end-cycle write");
      dflt(16'h7775); cyc(); lane(0, 1, 0, 16'h7776); cyc();
      finish_blk(16'h0800, 16'h7776, "R8 jump beats default");
      // R10 no leakage, back-to-back (R1)
      dflt(16'h8880); lane(0, 0, 0, 16'h8881); cyc();
      end_valid = 1'b1; end_addr = 16'h0900;
      q_exp.push_back(16'h8881); q_tag.push_back("R10 first block");
      @(negedge clk);
      end_addr = 16'h0A00;
      q_exp.push_back(16'h0A01); q_tag.push_back("R10 fresh block");
      cyc();
      cyc();
      check(next_valid == 1'b0, "R1 pulse ends", next_valid, 0);
      repeat (3) cyc();
      check(q_exp.size() == 0, "R1 all results issued", q_exp.size(), 0);
      summary();
   end
endmodule